// File: doc/BRIEF.md
# Supervisor Nested-Trap Guard

This block holds the supervisor trap-disable bit and the supervisor interrupt-enable bit, in two copies: one for the normal supervisor level and one for the virtualized supervisor level. Software updates these bits through CSR writes, and a supervisor return pulse clears the trap-disable bit. The virtualization flag chooses which copy a CSR write, a return or a trap acts on.

When a trap request aimed at the selected supervisor level arrives and that copy's trap-disable bit is clear, the block sets the bit and delivers the trap normally on its delegated strobe. If the bit is already set, the handler has been interrupted in a state it cannot re-enter. The block then escalates the trap to machine mode under a dedicated double-trap cause code. The cause the trap would have carried goes into the secondary trap-value output.

Two enables gate the feature. The machine-level enable turns it off entirely. The hypervisor-level enable turns it off for the virtualized copy only. The block also clears the double-trap position of the exception delegation mask, so a double trap can never be delegated.

Top module: `nest_trap_guard`

## Requirements
- R1: After reset, both trap-disable bits and both interrupt-enable bits read 0, and both delivery strobes are low.
- R2: A CSR write whose new trap-disable value is 1, to a copy whose feature is enabled, leaves that copy's interrupt-enable bit at 0, whatever interrupt-enable value the write carries.
- R3: A CSR write loads the written interrupt-enable value when the write's trap-disable value is 0 or the feature is disabled for that copy.
- R4: A trap request to a copy whose trap-disable bit reads 0 raises the delegated strobe for one cycle on the following cycle. The strobe carries the request's cause, value, PC and virtualization flag, and the copy's trap-disable bit then reads 1 when its feature is enabled.
- R5: A trap request to an enabled copy whose trap-disable bit reads 1 raises the machine strobe for exactly one cycle on the following cycle, while the delegated strobe stays low. The machine strobe carries cause 16, a secondary trap value equal to the original cause zero-extended, and the original value and PC.
- R6: An escalated trap leaves that copy's trap-disable and interrupt-enable bits unchanged.
- R7: A supervisor return pulse clears the selected copy's trap-disable bit.
- R8: With the virtualization flag at 1, writes, returns and traps act only on the virtual copy; with the flag at 0, they act only on the normal copy.
- R9: With the hypervisor-level enable at 0, the virtual trap-disable bit reads 0 and ignores writes, and virtual traps are always delivered on the delegated strobe. The bit still reads 0 after the enable returns to 1.
- R10: With the machine-level enable at 0, both trap-disable bits read 0 and ignore writes, and no trap escalates, whatever the hypervisor-level enable is.
- R11: The delegation-mask output equals its input, except that bit 16 is always 0.
- R12: In a single cycle, a trap request takes precedence over a return pulse, and a return pulse takes precedence over a CSR write. The lower-priority events in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| menv_dte_i | input | 1 | Machine-level double-trap enable |
| henv_dte_i | input | 1 | Hypervisor-level double-trap enable |
| virt_i | input | 1 | Virtualization flag, selects the copy |
| csr_wr_i | input | 1 | CSR write strobe for the status bits |
| csr_wdt_i | input | 1 | Written trap-disable value |
| csr_wie_i | input | 1 | Written interrupt-enable value |
| sret_i | input | 1 | Supervisor return retire pulse |
| trap_req_i | input | 1 | Trap request aimed at the supervisor level |
| trap_cause_i | input | CAUSE_W | Cause of the requested trap |
| trap_val_i | input | XLEN | Trap value of the request |
| trap_pc_i | input | XLEN | PC of the trapping instruction |
| edeleg_i | input | XLEN | Exception delegation mask as written |
| sdt_o | output | 1 | Normal trap-disable bit |
| sie_o | output | 1 | Normal interrupt-enable bit |
| vsdt_o | output | 1 | Virtual trap-disable bit |
| vsie_o | output | 1 | Virtual interrupt-enable bit |
| deleg_valid_o | output | 1 | Delegated delivery strobe |
| deleg_virt_o | output | 1 | Delegated delivery targets the virtual level |
| deleg_cause_o | output | CAUSE_W | Delegated cause |
| deleg_val_o | output | XLEN | Delegated trap value |
| deleg_pc_o | output | XLEN | Delegated PC |
| mdbl_valid_o | output | 1 | Machine-mode double-trap strobe |
| mdbl_cause_o | output | XLEN | Machine cause (16) |
| mdbl_tval2_o | output | XLEN | Original cause for the secondary trap value |
| mdbl_tval_o | output | XLEN | Machine trap value |
| mdbl_epc_o | output | XLEN | Machine exception PC |
| edeleg_o | output | XLEN | Delegation mask with bit 16 forced to 0 |

## Verification
On every cycle, the assertions check the normal-copy write rules for the interrupt-enable bit, that a return clears the trap-disable bit, and that the two strobes never fire together. They also check that a trap to a set bit escalates with the original cause in the secondary value. Only the bench scenarios show the virtual copy, the behaviour as the two enables drop and return, the precedence of same-cycle events, and the width of each strobe. They also show that an escalation leaves the bits untouched.

// File: rtl/ntg_pkg.sv
package ntg_pkg;
    localparam int unsigned NTG_COPIES = 2;
    localparam int unsigned NTG_NORM   = 0;
    localparam int unsigned NTG_VIRT   = 1;

    typedef struct packed {
        logic sdt;
        logic sie;
    } ntg_bits_t;

    typedef struct packed {
        ntg_bits_t [NTG_COPIES-1:0] cp;
        logic                       dlg;
        logic                       dlg_virt;
        logic                       esc;
    } ntg_state_t;
endpackage

// File: rtl/ntg_copy_next.sv
module ntg_copy_next
    import ntg_pkg::*;
(
    input  ntg_bits_t cur_i,
    input  logic      en_i,
    input  logic      sel_i,
    input  logic      trap_i,
    input  logic      sret_i,
    input  logic      wr_i,
    input  logic      wdt_i,
    input  logic      wie_i,
    output ntg_bits_t nxt_o,
    output logic      esc_o,
    output logic      take_o
);
    always_comb begin
        nxt_o  = cur_i;
        esc_o  = 1'b0;
        take_o = 1'b0;
        if (sel_i) begin
            if (trap_i) begin
                if (en_i && cur_i.sdt) begin
                    esc_o = 1'b1;
                end else begin
                    take_o    = 1'b1;
                    nxt_o.sdt = en_i;
                end
            end else if (sret_i) begin
                nxt_o.sdt = 1'b0;
            end else if (wr_i) begin
                nxt_o.sdt = wdt_i & en_i;
                nxt_o.sie = wie_i & ~(en_i & wdt_i);
            end
        end
        if (!en_i) begin
            nxt_o.sdt = 1'b0;
        end
    end
endmodule

// File: rtl/ntg_deleg_mask.sv
module ntg_deleg_mask #(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned CLEAR_BIT = 16
) (
    input  logic [XLEN-1:0] mask_i,
    output logic [XLEN-1:0] mask_o
);
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        if (b == CLEAR_BIT) begin : g_zero
            assign mask_o[b] = 1'b0;
        end else begin : g_pass
            assign mask_o[b] = mask_i[b];
        end
    end
endmodule

// File: rtl/nest_trap_guard.sv
module nest_trap_guard
    import ntg_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned CAUSE_W  = 6,
    parameter int unsigned DBL_CODE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               menv_dte_i,
    input  logic               henv_dte_i,
    input  logic               virt_i,
    input  logic               csr_wr_i,
    input  logic               csr_wdt_i,
    input  logic               csr_wie_i,
    input  logic               sret_i,
    input  logic               trap_req_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    input  logic [XLEN-1:0]    trap_val_i,
    input  logic [XLEN-1:0]    trap_pc_i,
    input  logic [XLEN-1:0]    edeleg_i,
    output logic               sdt_o,
    output logic               sie_o,
    output logic               vsdt_o,
    output logic               vsie_o,
    output logic               deleg_valid_o,
    output logic               deleg_virt_o,
    output logic [CAUSE_W-1:0] deleg_cause_o,
    output logic [XLEN-1:0]    deleg_val_o,
    output logic [XLEN-1:0]    deleg_pc_o,
    output logic               mdbl_valid_o,
    output logic [XLEN-1:0]    mdbl_cause_o,
    output logic [XLEN-1:0]    mdbl_tval2_o,
    output logic [XLEN-1:0]    mdbl_tval_o,
    output logic [XLEN-1:0]    mdbl_epc_o,
    output logic [XLEN-1:0]    edeleg_o
);
    localparam int unsigned PAD_W = XLEN - CAUSE_W;

    ntg_state_t state_d, state_q;
    logic [CAUSE_W-1:0] cause_d, cause_q;
    logic [XLEN-1:0]    val_d, val_q;
    logic [XLEN-1:0]    pc_d, pc_q;

    logic [NTG_COPIES-1:0] en_w, sel_w, esc_w, take_w;
    ntg_bits_t [NTG_COPIES-1:0] nxt_w;

    assign en_w[NTG_NORM]  = menv_dte_i;
    assign en_w[NTG_VIRT]  = menv_dte_i & henv_dte_i;
    assign sel_w[NTG_NORM] = ~virt_i;
    assign sel_w[NTG_VIRT] = virt_i;

    for (genvar c = 0; c < NTG_COPIES; c++) begin : g_copy
        ntg_copy_next u_next (
            .cur_i  (state_q.cp[c]),
            .en_i   (en_w[c]),
            .sel_i  (sel_w[c]),
            .trap_i (trap_req_i),
            .sret_i (sret_i),
            .wr_i   (csr_wr_i),
            .wdt_i  (csr_wdt_i),
            .wie_i  (csr_wie_i),
            .nxt_o  (nxt_w[c]),
            .esc_o  (esc_w[c]),
            .take_o (take_w[c])
        );
    end

    ntg_deleg_mask #(.XLEN(XLEN), .CLEAR_BIT(DBL_CODE)) u_mask (
        .mask_i (edeleg_i),
        .mask_o (edeleg_o)
    );

    always_comb begin
        state_d          = state_q;
        state_d.cp       = nxt_w;
        state_d.dlg      = |take_w;
        state_d.dlg_virt = virt_i & trap_req_i;
        state_d.esc      = |esc_w;
        cause_d          = cause_q;
        val_d            = val_q;
        pc_d             = pc_q;
        if (trap_req_i) begin
            cause_d = trap_cause_i;
            val_d   = trap_val_i;
            pc_d    = trap_pc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            cause_q <= '0;
            val_q   <= '0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            val_q   <= val_d;
            pc_q    <= pc_d;
        end
    end

    assign sdt_o  = state_q.cp[NTG_NORM].sdt & en_w[NTG_NORM];
    assign sie_o  = state_q.cp[NTG_NORM].sie;
    assign vsdt_o = state_q.cp[NTG_VIRT].sdt & en_w[NTG_VIRT];
    assign vsie_o = state_q.cp[NTG_VIRT].sie;

    assign deleg_valid_o = state_q.dlg;
    assign deleg_virt_o  = state_q.dlg_virt;
    assign deleg_cause_o = cause_q;
    assign deleg_val_o   = val_q;
    assign deleg_pc_o    = pc_q;

    assign mdbl_valid_o = state_q.esc;
    assign mdbl_cause_o = XLEN'(DBL_CODE);
    assign mdbl_tval2_o = {{PAD_W{1'b0}}, cause_q};
    assign mdbl_tval_o  = val_q;
    assign mdbl_epc_o   = pc_q;
endmodule

// File: rtl/ntg_chk.sv
module ntg_chk #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               menv_dte_i,
    input logic               virt_i,
    input logic               csr_wr_i,
    input logic               csr_wdt_i,
    input logic               csr_wie_i,
    input logic               sret_i,
    input logic               trap_req_i,
    input logic [CAUSE_W-1:0] trap_cause_i,
    input logic               sdt_o,
    input logic               sie_o,
    input logic               deleg_valid_o,
    input logic               mdbl_valid_o,
    input logic [XLEN-1:0]    mdbl_tval2_o
);
    // R2
    sdt_write_clears_sie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_i && !trap_req_i && !sret_i && !virt_i && menv_dte_i && csr_wdt_i) |=> !sie_o);

    // R3
    sie_rise_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sie_o) |-> $past(csr_wr_i && !trap_req_i && !sret_i && !virt_i && csr_wie_i
                               && !(menv_dte_i && csr_wdt_i)));

    // R5
    nested_trap_escalates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_i && !virt_i && menv_dte_i && sdt_o) |=> (mdbl_valid_o && !deleg_valid_o));

    // R5
    escalation_keeps_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdbl_valid_o |-> (mdbl_tval2_o == XLEN'($past(trap_cause_i))));

    // R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mdbl_valid_o, deleg_valid_o}));

    // R7
    sret_clears_sdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sret_i && !trap_req_i && !virt_i) |=> !sdt_o);
endmodule

bind nest_trap_guard ntg_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .menv_dte_i    (menv_dte_i),
    .virt_i        (virt_i),
    .csr_wr_i      (csr_wr_i),
    .csr_wdt_i     (csr_wdt_i),
    .csr_wie_i     (csr_wie_i),
    .sret_i        (sret_i),
    .trap_req_i    (trap_req_i),
    .trap_cause_i  (trap_cause_i),
    .sdt_o         (sdt_o),
    .sie_o         (sie_o),
    .deleg_valid_o (deleg_valid_o),
    .mdbl_valid_o  (mdbl_valid_o),
    .mdbl_tval2_o  (mdbl_tval2_o)
);

// File: tb/nest_trap_guard_test.sv
module nest_trap_guard_test;
    localparam int XLEN    = 64;
    localparam int CAUSE_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic menv_dte_i = 1'b0, henv_dte_i = 1'b0, virt_i = 1'b0;
    logic csr_wr_i = 1'b0, csr_wdt_i = 1'b0, csr_wie_i = 1'b0;
    logic sret_i = 1'b0, trap_req_i = 1'b0;
    logic [CAUSE_W-1:0] trap_cause_i = '0;
    logic [XLEN-1:0] trap_val_i = '0, trap_pc_i = '0, edeleg_i = '0;
    logic sdt_o, sie_o, vsdt_o, vsie_o;
    logic deleg_valid_o, deleg_virt_o, mdbl_valid_o;
    logic [CAUSE_W-1:0] deleg_cause_o;
    logic [XLEN-1:0] deleg_val_o, deleg_pc_o, mdbl_cause_o, mdbl_tval2_o, mdbl_tval_o, mdbl_epc_o, edeleg_o;

    nest_trap_guard #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) uut (.*);

    always #10 clk = ~clk;

    typedef struct {
        bit              esc;
        bit              virt;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0] val;
        logic [XLEN-1:0] pc;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a delivery strobe shows up
    always @(negedge clk) begin
        if (rst_n && (deleg_valid_o || mdbl_valid_o)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4/R5 unexpected delivery", {62'd0, mdbl_valid_o, deleg_valid_o}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(mdbl_valid_o == e.esc && deleg_valid_o == !e.esc, "R4/R5 delivery kind",
                    {62'd0, mdbl_valid_o, deleg_valid_o}, e.esc ? 2 : 1);
                if (e.esc) begin
                    chk(mdbl_cause_o == 16, "R5 mcause", mdbl_cause_o, 16);
                    chk(mdbl_tval2_o == XLEN'(e.cause), "R5 tval2", mdbl_tval2_o, XLEN'(e.cause));
                    chk(mdbl_tval_o == e.val && mdbl_epc_o == e.pc, "R5 tval/epc", mdbl_epc_o, e.pc);
                end else begin
                    chk(deleg_cause_o == e.cause, "R4 cause", XLEN'(deleg_cause_o), XLEN'(e.cause));
                    chk(deleg_val_o == e.val && deleg_pc_o == e.pc, "R4 val/pc", deleg_pc_o, e.pc);
                    chk(deleg_virt_o == e.virt, "R4 virt", XLEN'(deleg_virt_o), XLEN'(e.virt));
                end
            end
        end
    end

    task automatic do_write(input bit v, input bit dt, input bit ie);
        @(negedge clk);
        virt_i = v; csr_wr_i = 1'b1; csr_wdt_i = dt; csr_wie_i = ie;
        @(negedge clk);
        csr_wr_i = 1'b0;
    endtask

    task automatic do_sret(input bit v);
        @(negedge clk);
        virt_i = v; sret_i = 1'b1;
        @(negedge clk);
        sret_i = 1'b0;
    endtask

    task automatic do_trap(input bit v, input logic [CAUSE_W-1:0] c, input bit esc);
        exp_t e;
        @(negedge clk);
        virt_i = v; trap_req_i = 1'b1; trap_cause_i = c;
        trap_val_i = {32'hA5A5_0000, 26'd0, c}; trap_pc_i = 64'h8000_1000 + c;
        e.esc = esc; e.virt = v; e.cause = c; e.val = trap_val_i; e.pc = trap_pc_i;
        sb.push_back(e);
        @(negedge clk);
        trap_req_i = 1'b0;
        @(negedge clk);
        // R4 R5: strobe lasts exactly one cycle
        chk(!deleg_valid_o && !mdbl_valid_o, "R4/R5 strobe width", {62'd0, mdbl_valid_o, deleg_valid_o}, 0);
    endtask

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({sdt_o, sie_o, vsdt_o, vsie_o, deleg_valid_o, mdbl_valid_o} == 0, "R1 reset",
            {58'd0, sdt_o, sie_o, vsdt_o, vsie_o, deleg_valid_o, mdbl_valid_o}, 0);
        rst_n = 1'b1;
        menv_dte_i = 1'b1; henv_dte_i = 1'b1;

        do_write(0, 0, 1);
        chk(sie_o == 1 && sdt_o == 0, "R3 sie set with sdt clear", {62'd0, sdt_o, sie_o}, 1);
        do_write(0, 1, 1);
        chk(sdt_o == 1 && sie_o == 0, "R2 sdt write forces sie", {62'd0, sdt_o, sie_o}, 2);
        do_write(0, 1, 1);
        chk(sie_o == 0, "R2 sdt already set", XLEN'(sie_o), 0);
        do_write(0, 0, 0);

        do_trap(0, 6'd13, 0);
        chk(sdt_o == 1, "R4 sdt set by trap", XLEN'(sdt_o), 1);
        do_trap(0, 6'd5, 1);
        chk(sdt_o == 1 && sie_o == 0, "R6 escalation keeps bits", {62'd0, sdt_o, sie_o}, 2);
        do_sret(0);
        chk(sdt_o == 0, "R7 sret clears sdt", XLEN'(sdt_o), 0);

        do_write(0, 0, 1);
        do_write(1, 0, 1);
        chk(vsie_o == 1 && vsdt_o == 0, "R8 virtual sie write", {62'd0, vsdt_o, vsie_o}, 1);
        do_write(1, 1, 1);
        chk(vsdt_o == 1 && vsie_o == 0 && sdt_o == 0 && sie_o == 1, "R8 copies separate",
            {60'd0, vsdt_o, vsie_o, sdt_o, sie_o}, 4'b1001);
        do_trap(1, 6'd7, 1);
        chk(vsdt_o == 1, "R6 virtual escalation keeps sdt", XLEN'(vsdt_o), 1);
        do_sret(1);
        chk(vsdt_o == 0 && sie_o == 1, "R7 R8 virtual sret", {62'd0, vsdt_o, sie_o}, 1);
        do_trap(1, 6'd9, 0);
        chk(vsdt_o == 1, "R4 virtual trap sets sdt", XLEN'(vsdt_o), 1);

        @(negedge clk); henv_dte_i = 1'b0;
        @(negedge clk);
        chk(vsdt_o == 0, "R9 virtual sdt reads 0", XLEN'(vsdt_o), 0);
        do_write(1, 1, 1);
        chk(vsdt_o == 0 && vsie_o == 1, "R9 write ignored, sie free", {62'd0, vsdt_o, vsie_o}, 1);
        do_trap(1, 6'd4, 0);
        do_trap(1, 6'd4, 0);
        @(negedge clk); henv_dte_i = 1'b1;
        @(negedge clk);
        chk(vsdt_o == 0, "R9 stays 0 after enable", XLEN'(vsdt_o), 0);

        do_write(0, 1, 0);
        @(negedge clk); menv_dte_i = 1'b0;
        @(negedge clk);
        chk(sdt_o == 0 && vsdt_o == 0, "R10 both read 0", {62'd0, sdt_o, vsdt_o}, 0);
        do_write(0, 1, 1);
        chk(sdt_o == 0 && sie_o == 1, "R10 write ignored", {62'd0, sdt_o, sie_o}, 1);
        do_trap(0, 6'd2, 0);
        do_trap(0, 6'd2, 0);
        @(negedge clk); menv_dte_i = 1'b1;
        @(negedge clk);
        chk(sdt_o == 0, "R10 stays 0 after enable", XLEN'(sdt_o), 0);

        // R12: trap beats a same-cycle write
        begin
            exp_t e;
            @(negedge clk);
            virt_i = 0; trap_req_i = 1; trap_cause_i = 6'd3; trap_val_i = 64'h33; trap_pc_i = 64'h44;
            csr_wr_i = 1; csr_wdt_i = 0; csr_wie_i = 0;
            e.esc = 0; e.virt = 0; e.cause = 6'd3; e.val = 64'h33; e.pc = 64'h44;
            sb.push_back(e);
            @(negedge clk);
            trap_req_i = 0; csr_wr_i = 0;
            chk(sdt_o == 1 && sie_o == 1, "R12 trap over write", {62'd0, sdt_o, sie_o}, 3);
            // R12: return beats a same-cycle write
            sret_i = 1; csr_wr_i = 1; csr_wdt_i = 1; csr_wie_i = 0;
            @(negedge clk);
            sret_i = 0; csr_wr_i = 0;
            chk(sdt_o == 0 && sie_o == 1, "R12 sret over write", {62'd0, sdt_o, sie_o}, 1);
        end

        edeleg_i = '1;
        #1 chk(edeleg_o == ~(64'd1 << 16), "R11 mask all ones", edeleg_o, ~(64'd1 << 16));
        edeleg_i = 64'h1_0000;
        #1 chk(edeleg_o == 0, "R11 bit 16 only", edeleg_o, 0);
        edeleg_i = 64'h8000_0000_0000_B105;
        #1 chk(edeleg_o == 64'h8000_0000_0000_B105, "R11 other bits pass", edeleg_o, 64'h8000_0000_0000_B105);

        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R4/R5 deliveries outstanding", sb.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule